// File: doc/BRIEF.md
# Calendar Time Counter with Staged Commit

This block keeps a running calendar (second, minute, hour, day of month, day of week, month and year offset) advanced by a one-cycle tick pulse once per second. Software reads the live count and writes new values through a simple word-addressed register port.

Writes to the time fields never touch the running count. They land in a staging copy instead. A write of 1 to a trigger register starts a fixed-length commit sequence. At the end of that sequence the staging copy is loaded into the counters. A busy flag in the control register stays high for the whole sequence, and ticks that arrive during it are dropped.

Because reads always return the live count, software can detect a seconds carry between two reads by seeing the seconds value go down.

Top module: `cal_counter`

## Requirements
- R1: After reset the live count and the staging copy both hold second 0, minute 0, hour 0, day 1, weekday 0, month 1 and year 0, and the busy flag reads 0.
- R2: Reads at byte addresses 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28 and 0x2C return the live second, minute, hour, day of month, weekday, month and year, zero-extended to 32 bits. A read of an unmapped address returns 0.
- R3: A write to a field address updates only the staging copy, so the live value is unchanged until a commit. The stored value keeps only the field's width: 6 bits for second and minute, 5 for hour and day, 3 for weekday, 4 for month and 7 for year.
- R4: A write to 0x78 with bit 0 set, made while idle, starts a commit, and bit 6 of the control register at 0x00 then reads 1 for exactly COMMIT_CYCLES cycles. A trigger write with bit 0 clear does nothing. Writes to 0x00 have no effect.
- R5: The staged values appear in the live count COMMIT_CYCLES-1 clock edges after the trigger write edge, which is the last cycle in which busy reads 1.
- R6: A tick that arrives while busy is high is discarded, so after the commit the live count equals the staged values exactly.
- R7: A trigger write that arrives while a commit is running is ignored and does not lengthen the busy period.
- R8: On a tick, the second count goes from 59 to 0 and carries into the minute. The minute goes from 59 to 0 and carries into the hour. The hour goes from 23 to 0 and carries into the day.
- R9: The day of month goes back to 1 and carries into the month after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. February ends after day 29 when the year offset is a multiple of 4, and after day 28 otherwise.
- R10: Month 12 goes to 1 and increments the year. Year 127 goes to 0.
- R11: The weekday goes up by one on every day carry and goes from 6 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, one per second |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, together with req_i |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |

## Verification
The bench builds the block with its defaults: a commit length of 4 cycles and an 8-bit address. With these settings the full busy window can be counted edge by edge, and a second trigger or a tick can be placed inside that window. Any calendar state, including year 127 on the last second of December and leap and non-leap February ends, can be committed directly. This brings every rollover within reach in a few ticks, with no need to run through long spans of time.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_FIELDS = 7;
  localparam int FIELD_W    = 7;
  localparam int BUSY_BIT   = 6;
  localparam logic [7:0] CTRL_OFS  = 8'h00;
  localparam logic [7:0] FIELD_OFS = 8'h14;
  localparam logic [7:0] TRIG_OFS  = 8'h78;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [2:0] dow;
    logic [4:0] dom;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  localparam cal_time_t CAL_RESET = '{year: 7'd0, mon: 4'd1, dow: 3'd0,
                                      dom: 5'd1, hour: 5'd0, min: 6'd0, sec: 6'd0};

  // index order: 0 sec, 1 min, 2 hour, 3 dom, 4 dow, 5 mon, 6 year
  function automatic logic [FIELD_W-1:0] get_field(cal_time_t t, int idx);
    case (idx)
      0:       return {1'b0, t.sec};
      1:       return {1'b0, t.min};
      2:       return {2'b0, t.hour};
      3:       return {2'b0, t.dom};
      4:       return {4'b0, t.dow};
      5:       return {3'b0, t.mon};
      default: return t.year;
    endcase
  endfunction

  function automatic cal_time_t put_field(cal_time_t t, int idx, logic [FIELD_W-1:0] v);
    cal_time_t r = t;
    case (idx)
      0:       r.sec  = v[5:0];
      1:       r.min  = v[5:0];
      2:       r.hour = v[4:0];
      3:       r.dom  = v[4:0];
      4:       r.dow  = v[2:0];
      5:       r.mon  = v[3:0];
      default: r.year = v;
    endcase
    return r;
  endfunction

  function automatic logic [4:0] month_len(logic [3:0] mon, logic [6:0] year);
    case (mon)
      4'd2:                      return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_regs.sv
module cal_regs
  import cal_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  cal_time_t         live_i,
  output cal_time_t         stage_o,
  output logic              trig_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic                  wr;
  logic [NUM_FIELDS-1:0] fld_hit;
  cal_time_t             stage_q, stage_d;

  assign wr = req_i && we_i;

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_dec
    assign fld_hit[gi] = (addr_i == ADDR_W'(FIELD_OFS) + ADDR_W'(4 * gi));
  end

  always_comb begin
    stage_d = stage_q;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (wr && fld_hit[i]) stage_d = put_field(stage_q, i, wdata_i[FIELD_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= CAL_RESET;
    else         stage_q <= stage_d;
  end

  assign stage_o = stage_q;
  assign trig_o  = wr && (addr_i == ADDR_W'(TRIG_OFS)) && wdata_i[0];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(CTRL_OFS)) rdata_o[BUSY_BIT] = busy_i;
    for (int i = 0; i < NUM_FIELDS; i++)
      if (fld_hit[i]) rdata_o = DATA_W'(get_field(live_i, i));
  end
endmodule

// File: rtl/cal_commit.sv
module cal_commit #(
  parameter int COMMIT_CYCLES = 4,
  localparam int CNT_W = $clog2(COMMIT_CYCLES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o,
  output logic copy_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  // copy in the second-to-last busy cycle, busy drops one edge later
  assign copy_o = busy_q && (cnt_q == CNT_W'(1));
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (trig_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(COMMIT_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  cal_time_t load_val_i,
  output cal_time_t live_o
);
  cal_time_t live_q, live_d;

  always_comb begin
    live_d = live_q;
    if (load_i) begin
      live_d = load_val_i;
    end else if (tick_i) begin
      if (live_q.sec < 6'd59) live_d.sec = live_q.sec + 6'd1;
      else begin
        live_d.sec = '0;
        if (live_q.min < 6'd59) live_d.min = live_q.min + 6'd1;
        else begin
          live_d.min = '0;
          if (live_q.hour < 5'd23) live_d.hour = live_q.hour + 5'd1;
          else begin
            live_d.hour = '0;
            live_d.dow  = (live_q.dow >= 3'd6) ? 3'd0 : live_q.dow + 3'd1;
            if (live_q.dom < month_len(live_q.mon, live_q.year))
              live_d.dom = live_q.dom + 5'd1;
            else begin
              live_d.dom = 5'd1;
              if (live_q.mon < 4'd12) live_d.mon = live_q.mon + 4'd1;
              else begin
                live_d.mon  = 4'd1;
                live_d.year = live_q.year + 7'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= CAL_RESET;
    else         live_q <= live_d;
  end

  assign live_o = live_q;
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 32,
  parameter int COMMIT_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  cal_time_t live, stage;
  logic      trig, busy, copy;

  cal_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .busy_i(busy), .live_i(live), .stage_o(stage), .trig_o(trig), .rdata_o
  );

  cal_commit #(.COMMIT_CYCLES(COMMIT_CYCLES)) commit_i (
    .clk_i, .rst_ni, .trig_i(trig), .busy_o(busy), .copy_o(copy)
  );

  // ticks are dropped for the whole busy window
  cal_time_core core_i (
    .clk_i, .rst_ni, .tick_i(tick_i && !busy), .load_i(copy),
    .load_val_i(stage), .live_o(live)
  );
endmodule

// File: rtl/cal_counter_chk.sv
module cal_counter_chk
  import cal_pkg::*;
#(
  parameter int COMMIT_CYCLES = 4
) (
  input logic      clk_i,
  input logic      rst_ni,
  input logic      tick_i,
  input logic      trig_i,
  input logic      busy_i,
  input logic      copy_i,
  input cal_time_t live_i
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= run_q + 16'd1;
    else             run_q <= '0;
  end

  a_r4_trig_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !busy_i) |=> busy_i);

  a_r7_busy_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (run_q == 16'(COMMIT_CYCLES)));

  a_r5_stable_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $stable(live_i));

  a_r6_no_tick_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !copy_i) |=> $stable(live_i));

  a_r8_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && tick_i && live_i.sec < 6'd59) |=> (live_i.sec == $past(live_i.sec) + 6'd1));
endmodule

bind cal_counter cal_counter_chk #(.COMMIT_CYCLES(COMMIT_CYCLES)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .trig_i(trig),
  .busy_i(busy), .copy_i(copy), .live_i(live)
);

// File: tb/cal_counter_tb_top.sv
module cal_counter_tb_top;
  localparam int NC = 4;
  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  int passed = 0, total = 0;
  int m[7];

  always #4 clk_i = ~clk_i;

  cal_counter #(.COMMIT_CYCLES(NC)) dut_i (.*);

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
  endtask

  function automatic int mlen(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic void adv();
    m[0]++;
    if (m[0] == 60) begin
      m[0] = 0; m[1]++;
      if (m[1] == 60) begin
        m[1] = 0; m[2]++;
        if (m[2] == 24) begin
          m[2] = 0; m[4] = (m[4] + 1) % 7; m[3]++;
          if (m[3] > mlen(m[5], m[6])) begin
            m[3] = 1; m[5]++;
            if (m[5] == 13) begin m[5] = 1; m[6] = (m[6] + 1) % 128; end
          end
        end
      end
    end
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic check_all(input string rq);
    logic [31:0] d;
    for (int i = 0; i < 7; i++) begin
      rd(8'h14 + 8'(4 * i), d);
      chk(d == 32'(m[i]), rq, $sformatf("field %0d", i), int'(d), m[i]);
    end
  endtask

  // trigger and count busy cycles; optional second trigger and tick inside window
  task automatic commit(input bit retrig, input bit tick_in, output int n);
    logic [31:0] d;
    wr(8'h78, 32'h1);
    n = 0;
    rd(8'h00, d);
    while (d[6] && n < 100) begin
      n++;
      if (n == 2) begin
        req_i = retrig; we_i = retrig; addr_i = 8'h78; wdata_i = 32'h1; tick_i = tick_in;
      end
      @(negedge clk_i);
      req_i = 0; we_i = 0; tick_i = 0;
      rd(8'h00, d);
    end
  endtask

  task automatic set_time(input int v[7], input string rq);
    int n;
    for (int i = 0; i < 7; i++) begin m[i] = v[i]; wr(8'h14 + 8'(4 * i), 32'(v[i])); end
    commit(0, 0, n);
    chk(n == NC, "R4", "busy cycles", n, NC);
    check_all(rq);
  endtask

  task automatic ticks(input int k);
    @(negedge clk_i); tick_i = 1;
    repeat (k) @(negedge clk_i);
    tick_i = 0;
    for (int i = 0; i < k; i++) adv();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    m = '{0, 0, 0, 1, 0, 1, 0};
    check_all("R1");
    rd(8'h00, d); chk(d == 0, "R1", "ctrl", int'(d), 0);

    // R2 unmapped read
    rd(8'h30, d); chk(d == 0, "R2", "unmapped", int'(d), 0);

    // R3 staging only, truncation
    wr(8'h14, 32'h2A);
    wr(8'h18, 32'hFFC5);
    rd(8'h14, d); chk(d == 0, "R3", "live sec before commit", int'(d), 0);
    // R4 trigger with bit0 clear and control writes do nothing
    wr(8'h78, 32'h2);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk(d == 0, "R4", "no busy", int'(d), 0);
    rd(8'h14, d); chk(d == 0, "R4", "sec unchanged", int'(d), 0);
    commit(0, 0, n);
    chk(n == NC, "R4", "busy cycles", n, NC);
    rd(8'h18, d); chk(d == 5, "R3", "min truncated", int'(d), 5);
    rd(8'h14, d); chk(d == 32'h2A, "R3", "sec committed", int'(d), 32'h2A);

    // R5 live updated in last busy cycle
    wr(8'h14, 32'd17);
    wr(8'h78, 32'h1);
    repeat (NC - 2) @(negedge clk_i);
    rd(8'h14, d); chk(d == 32'h2A, "R5", "sec before copy", int'(d), 32'h2A);
    @(negedge clk_i);
    rd(8'h14, d); chk(d == 17, "R5", "sec at copy", int'(d), 17);
    rd(8'h00, d); chk(d[6] == 1'b1, "R5", "busy at copy", int'(d[6]), 1);
    @(negedge clk_i);
    rd(8'h00, d); chk(d[6] == 1'b0, "R5", "busy after", int'(d[6]), 0);

    // R6 tick in window, R7 retrigger in window
    set_time('{10, 20, 5, 3, 2, 7, 19}, "R2");
    wr(8'h14, 32'd40);
    commit(1, 1, n);
    chk(n == NC, "R7", "retrigger busy cycles", n, NC);
    rd(8'h14, d); chk(d == 40, "R6", "tick dropped", int'(d), 40);
    m[0] = 40;

    // R8..R11 directed rollovers
    set_time('{59, 59, 23, 31, 6, 12, 127}, "R10");
    ticks(1); check_all("R10");
    set_time('{59, 59, 23, 28, 1, 2, 4}, "R9");
    ticks(1); check_all("R9");
    set_time('{59, 59, 23, 28, 1, 2, 5}, "R9");
    ticks(1); check_all("R9");
    set_time('{59, 59, 23, 30, 5, 4, 9}, "R11");
    ticks(1); check_all("R11");
    set_time('{58, 59, 22, 1, 3, 1, 0}, "R8");
    ticks(3); check_all("R8");

    // random states and tick bursts
    for (int it = 0; it < 40; it++) begin
      int v[7];
      v[6] = $urandom % 128; v[5] = 1 + $urandom % 12;
      v[3] = 1 + $urandom % mlen(v[5], v[6]); v[4] = $urandom % 7;
      v[2] = $urandom % 24; v[1] = $urandom % 60; v[0] = 50 + $urandom % 10;
      if (it % 4 == 0) begin v[1] = 59; v[2] = 23; v[3] = mlen(v[5], v[6]); end
      set_time(v, "R2");
      ticks(1 + $urandom % 200);
      check_all("R8");
    end

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule